// File: doc/BRIEF.md
# Physical Read Router with Typed Access Faults

This block sits between a core's physical read path and three targets: a timer/interrupt register block, a host-interface mailbox and main memory. Each request carries a physical address, an access size and an access kind. The block checks the memory-mapped register regions first. Within that space it checks the timer block before the mailbox. Only an address that neither register region claims goes to the main memory range.

Register targets are decoded inside the block and answer exactly one cycle after the request. Main memory sits behind a plain request port. A memory request leaves in the same cycle as the core's request, and the memory's answer is passed back in the cycle the memory marks it valid.

When no target accepts the address, size and alignment, the block answers with a fault in place of data. The fault code depends on the access kind. An instruction fetch gets one code, a data read another, and every other kind (store or atomic) a third. The same kind-based choice is made at every point where a request can be rejected.

Top module: `phys_read_router`

## Requirements
- R1: While and after reset, and until the first request, `rsp_valid` and `mem_req_valid` stay low.
- R2: An access that fits wholly inside the main memory range and touches no register region asserts `mem_req_valid` in the same cycle, with `mem_req_addr`/`mem_req_size` equal to the request. `req_size` encodes 0=1 byte, 1=2, 2=4, 3=8. The memory's data is returned with `rsp_valid` high and `rsp_fault` low in the cycle `mem_rsp_valid` is high.
- R3: The timer block accepts the following reads, at offsets from its base. Offset 0x0, size 4 or 8, returns the software-interrupt bit zero-extended. Offsets 0x4000 (compare) and 0xBFF8 (time), size 8, return the full 64-bit register; size 4 returns bits 31:0. Offsets 0x4004 and 0xBFFC, size 4, return bits 63:32 of compare and of time.
- R4: Any other offset or size inside the timer range faults. This includes a 2-byte read at offset 0x0, an 8-byte read at 0x4004 and any read at offset 0x10.
- R5: A 4-byte read at the mailbox base returns bits 31:0 of the 64-bit host word, and a 4-byte read at base+4 returns bits 63:32. Both are zero-extended.
- R6: Any other access inside the mailbox range faults. This includes an 8-byte read at the base and a 4-byte read at base+8.
- R7: The fault code follows `req_kind`. Execute (0) gives 1, data read (1) gives 5, and store (2) or atomic (3) gives 7. This holds for every kind of rejection.
- R8: An address in no region faults. So does an access that starts inside a region but runs past its end, because the whole access must fit.
- R9: Register and fault responses come exactly one cycle after the request. These requests never raise `mem_req_valid`. On a fault, `rsp_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present this cycle |
| req_addr | input | ADDR_W | Physical address |
| req_size | input | 2 | Log2 of access size in bytes |
| req_kind | input | 2 | 0 execute, 1 data read, 2 store, 3 atomic |
| tmr_sip | input | 1 | Software-interrupt pending bit |
| tmr_cmp | input | 64 | Timer compare register value |
| tmr_time | input | 64 | Timer counter value |
| host_word | input | 64 | Host mailbox word |
| mem_req_valid | output | 1 | Request to main memory |
| mem_req_addr | output | ADDR_W | Address to main memory |
| mem_req_size | output | 2 | Size to main memory |
| mem_rsp_valid | input | 1 | Main memory data valid |
| mem_rsp_data | input | 64 | Main memory data |
| rsp_valid | output | 1 | Response valid |
| rsp_data | output | 64 | Response data, zero on fault |
| rsp_fault | output | 1 | Response is an access fault |
| rsp_cause | output | 4 | Fault code, zero when no fault |

## Verification
The assertions assume that at most one request is in flight. A new request never arrives while a register response is pending, and `mem_rsp_valid` only comes for a request that went to memory. They also assume that `mem_rsp_valid` never coincides with a register response. The stimulus issues one request at a time. It waits for that request's answer and then leaves an idle cycle before the next. The bench's memory model returns data only after a request it has seen on `mem_req_valid`.

// File: rtl/prr_pkg.sv
// Shared types and helpers for the physical read router.
// Assumes a 64-bit data path; sizes are encoded as log2(bytes).
package prr_pkg;

    typedef enum logic [1:0] {
        KIND_EXEC  = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2,
        KIND_AMO   = 2'd3
    } acc_kind_e;

    localparam logic [3:0] CAUSE_FETCH_FAULT = 4'd1;
    localparam logic [3:0] CAUSE_LOAD_FAULT  = 4'd5;
    localparam logic [3:0] CAUSE_STORE_FAULT = 4'd7;

    // Number of bytes covered by a log2 size code.
    function automatic logic [3:0] size_bytes(input logic [1:0] sz);
        return 4'd1 << sz;
    endfunction

    // Fault code chosen by access kind.
    function automatic logic [3:0] cause_for(input logic [1:0] kind);
        case (kind)
            KIND_EXEC: return CAUSE_FETCH_FAULT;
            KIND_LOAD: return CAUSE_LOAD_FAULT;
            default:   return CAUSE_STORE_FAULT;
        endcase
    endfunction

endpackage

// File: rtl/prr_region_match.sv
// Region test: high when the whole access [addr, addr+nbytes) lies inside
// [BASE, BASE+SIZE). Assumes BASE+SIZE fits in ADDR_W+1 bits.
module prr_region_match #(
    parameter int             ADDR_W = 32,
    parameter longint unsigned BASE  = 0,
    parameter longint unsigned SIZE  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        nbytes,
    output logic              hit
);
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE + SIZE);

    logic [ADDR_W:0] start_w;
    logic [ADDR_W:0] end_w;

    // Compare both ends of the access with one extra bit against wrap.
    always_comb begin
        start_w = {1'b0, addr};
        end_w   = start_w + {{(ADDR_W-3){1'b0}}, nbytes};
        hit     = (start_w >= LO) && (end_w <= HI);
    end
endmodule

// File: rtl/prr_timer_decode.sv
// Timer/interrupt register decode. Accepts only exact aligned 4- or
// 8-byte reads at the defined offsets; assumes the caller has already
// confirmed the access lies in the timer range.
module prr_timer_decode #(
    parameter int             ADDR_W = 32,
    parameter longint unsigned BASE  = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              sip,
    input  logic [63:0]       cmp,
    input  logic [63:0]       tval,
    output logic              ok,
    output logic [63:0]       data
);
    localparam logic [ADDR_W-1:0] OFF_SIP    = ADDR_W'(32'h0000);
    localparam logic [ADDR_W-1:0] OFF_CMP_LO = ADDR_W'(32'h4000);
    localparam logic [ADDR_W-1:0] OFF_CMP_HI = ADDR_W'(32'h4004);
    localparam logic [ADDR_W-1:0] OFF_TIM_LO = ADDR_W'(32'hBFF8);
    localparam logic [ADDR_W-1:0] OFF_TIM_HI = ADDR_W'(32'hBFFC);

    logic [ADDR_W-1:0] off;
    logic              sz4;
    logic              sz8;

    // Match offset and size against the register list.
    always_comb begin
        off  = addr - ADDR_W'(BASE);
        sz4  = (size == 2'd2);
        sz8  = (size == 2'd3);
        ok   = 1'b0;
        data = '0;
        if (off == OFF_SIP && (sz4 || sz8)) begin
            ok   = 1'b1;
            data = {63'b0, sip};
        end else if (off == OFF_CMP_LO && (sz4 || sz8)) begin
            ok   = 1'b1;
            data = sz8 ? cmp : {32'b0, cmp[31:0]};
        end else if (off == OFF_CMP_HI && sz4) begin
            ok   = 1'b1;
            data = {32'b0, cmp[63:32]};
        end else if (off == OFF_TIM_LO && (sz4 || sz8)) begin
            ok   = 1'b1;
            data = sz8 ? tval : {32'b0, tval[31:0]};
        end else if (off == OFF_TIM_HI && sz4) begin
            ok   = 1'b1;
            data = {32'b0, tval[63:32]};
        end
    end
endmodule

// File: rtl/prr_host_decode.sv
// Host mailbox decode: two 4-byte halves of one 64-bit word. Assumes the
// caller has already confirmed the access lies in the mailbox range.
module prr_host_decode #(
    parameter int             ADDR_W = 32,
    parameter longint unsigned BASE  = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [63:0]       word,
    output logic              ok,
    output logic [63:0]       data
);
    logic [ADDR_W-1:0] off;

    // Select the low or high half for a 4-byte read, reject anything else.
    always_comb begin
        off  = addr - ADDR_W'(BASE);
        ok   = 1'b0;
        data = '0;
        if (size == 2'd2 && off == '0) begin
            ok   = 1'b1;
            data = {32'b0, word[31:0]};
        end else if (size == 2'd2 && off == ADDR_W'(4)) begin
            ok   = 1'b1;
            data = {32'b0, word[63:32]};
        end
    end
endmodule

// File: rtl/phys_read_router.sv
// Physical read router. Register regions (timer first, then mailbox) take
// priority over main memory; unclaimed or rejected accesses fault with a
// code chosen by access kind. Assumes one request in flight at a time.
module phys_read_router #(
    parameter int             ADDR_W    = 32,
    parameter longint unsigned TMR_BASE  = 64'h0200_0000,
    parameter longint unsigned TMR_SIZE  = 64'h0000_C000,
    parameter longint unsigned HOST_BASE = 64'h4000_1000,
    parameter longint unsigned HOST_SIZE = 64'h0000_0010,
    parameter longint unsigned MEM_BASE  = 64'h8000_0000,
    parameter longint unsigned MEM_SIZE  = 64'h1000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_kind,
    input  logic              tmr_sip,
    input  logic [63:0]       tmr_cmp,
    input  logic [63:0]       tmr_time,
    input  logic [63:0]       host_word,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [1:0]        mem_req_size,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    output logic              rsp_fault,
    output logic [3:0]        rsp_cause
);
    import prr_pkg::*;

    localparam int NREG = 3;
    localparam int RG_TMR  = 0;
    localparam int RG_HOST = 1;
    localparam int RG_MEM  = 2;
    localparam longint unsigned RG_BASE [NREG] = '{TMR_BASE, HOST_BASE, MEM_BASE};
    localparam longint unsigned RG_SIZE [NREG] = '{TMR_SIZE, HOST_SIZE, MEM_SIZE};

    logic [3:0]      nbytes;
    logic [NREG-1:0] rg_hit;
    logic            tmr_ok,  host_ok;
    logic [63:0]     tmr_data, host_data;
    logic            loc_ok;
    logic [63:0]     loc_data;
    logic            mem_sel;

    logic            loc_vld_q;
    logic            loc_fault_q;
    logic [63:0]     loc_data_q;
    logic [3:0]      loc_cause_q;

    assign nbytes = size_bytes(req_size);

    for (genvar g = 0; g < NREG; g++) begin : g_region
        prr_region_match #(
            .ADDR_W (ADDR_W),
            .BASE   (RG_BASE[g]),
            .SIZE   (RG_SIZE[g])
        ) u_match (
            .addr   (req_addr),
            .nbytes (nbytes),
            .hit    (rg_hit[g])
        );
    end

    prr_timer_decode #(.ADDR_W(ADDR_W), .BASE(TMR_BASE)) u_timer (
        .addr (req_addr),
        .size (req_size),
        .sip  (tmr_sip),
        .cmp  (tmr_cmp),
        .tval (tmr_time),
        .ok   (tmr_ok),
        .data (tmr_data)
    );

    prr_host_decode #(.ADDR_W(ADDR_W), .BASE(HOST_BASE)) u_host (
        .addr (req_addr),
        .size (req_size),
        .word (host_word),
        .ok   (host_ok),
        .data (host_data)
    );

    // Priority select: timer, then mailbox, then memory; else reject.
    always_comb begin
        loc_ok   = 1'b0;
        loc_data = '0;
        mem_sel  = 1'b0;
        if (rg_hit[RG_TMR]) begin
            loc_ok   = tmr_ok;
            loc_data = tmr_data;
        end else if (rg_hit[RG_HOST]) begin
            loc_ok   = host_ok;
            loc_data = host_data;
        end else if (rg_hit[RG_MEM]) begin
            mem_sel  = 1'b1;
        end
    end

    // Forward memory-bound requests in the same cycle.
    assign mem_req_valid = req_valid && mem_sel;
    assign mem_req_addr  = req_addr;
    assign mem_req_size  = req_size;

    // Register the local (register or fault) answer for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_vld_q   <= 1'b0;
            loc_fault_q <= 1'b0;
            loc_data_q  <= '0;
            loc_cause_q <= '0;
        end else begin
            loc_vld_q   <= req_valid && !mem_sel;
            loc_fault_q <= !loc_ok;
            loc_data_q  <= loc_ok ? loc_data : 64'd0;
            loc_cause_q <= loc_ok ? 4'd0 : cause_for(req_kind);
        end
    end

    // Merge the local and memory answers onto the response port.
    always_comb begin
        rsp_valid = loc_vld_q || mem_rsp_valid;
        rsp_data  = loc_vld_q ? loc_data_q : mem_rsp_data;
        rsp_fault = loc_vld_q && loc_fault_q;
        rsp_cause = rsp_fault ? loc_cause_q : 4'd0;
    end
endmodule

// File: rtl/phys_read_router_chk.sv
// Property checker for the physical read router, bound to every instance.
// Assumes at most one request in flight and no overlap of memory and
// local responses.
module phys_read_router_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic              mem_req_valid,
    input logic              mem_rsp_valid,
    input logic [63:0]       mem_rsp_data,
    input logic              rsp_valid,
    input logic [63:0]       rsp_data,
    input logic              rsp_fault,
    input logic [3:0]        rsp_cause
);
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !mem_rsp_valid) |-> $past(req_valid));

    p_mem_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (rsp_valid && !rsp_fault && rsp_data == mem_rsp_data));

    p_local_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_req_valid) |=> rsp_valid);

    p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_data == 64'd0 && rsp_valid));

    p_exec_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_req_valid && req_kind == 2'd0)
            |=> (!rsp_fault || rsp_cause == 4'd1));

    p_load_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_req_valid && req_kind == 2'd1)
            |=> (!rsp_fault || rsp_cause == 4'd5));

    p_store_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_req_valid && req_kind[1])
            |=> (!rsp_fault || rsp_cause == 4'd7));
endmodule

bind phys_read_router phys_read_router_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_data      (rsp_data),
    .rsp_fault     (rsp_fault),
    .rsp_cause     (rsp_cause)
);

// File: tb/phys_read_router_bench.sv
// Scoreboard bench: driver tasks queue expected responses, a monitor
// process compares each response as it appears.
module phys_read_router_bench;
    localparam int ADDR_W = 32;
    localparam logic [31:0] TB = 32'h0200_0000;
    localparam logic [31:0] HB = 32'h4000_1000;
    localparam logic [31:0] MB = 32'h8000_0000;
    localparam logic [31:0] MEND = 32'h9000_0000;

    localparam logic [63:0] CMP_V  = 64'h1122_3344_5566_7788;
    localparam logic [63:0] TIME_V = 64'h0A0B_0C0D_0E0F_1011;
    localparam logic [63:0] HOST_V = 64'hDEAD_BEEF_CAFE_F00D;

    typedef struct {
        logic [63:0] data;
        logic        fault;
        logic [3:0]  cause;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = '0;
    logic [1:0]        req_kind = '0;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [1:0]        mem_req_size;
    logic              mem_rsp_valid = 1'b0;
    logic [63:0]       mem_rsp_data = '0;
    logic              rsp_valid;
    logic [63:0]       rsp_data;
    logic              rsp_fault;
    logic [3:0]        rsp_cause;

    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];
    bit   done = 1'b0;

    always #4 clk = ~clk;

    phys_read_router u_phys_read_router (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .req_kind      (req_kind),
        .tmr_sip       (1'b1),
        .tmr_cmp       (CMP_V),
        .tmr_time      (TIME_V),
        .host_word     (HOST_V),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_size  (mem_req_size),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_data),
        .rsp_fault     (rsp_fault),
        .rsp_cause     (rsp_cause)
    );

    function automatic logic [3:0] exp_cause(input logic [1:0] kind);
        if (kind == 2'd0) return 4'd1;
        if (kind == 2'd1) return 4'd5;
        return 4'd7;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Register or fault access: expect an answer the next cycle.
    task automatic do_local(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] k,
                            input logic flt, input logic [63:0] d, input string tag);
        exp_t e;
        e.data  = flt ? 64'd0 : d;
        e.fault = flt;
        e.cause = flt ? exp_cause(k) : 4'd0;
        e.tag   = tag;
        @(negedge clk);
        sb.push_back(e);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_kind = k;
        #1;
        check({tag, " R9 no mem req"}, {63'b0, mem_req_valid}, 64'd0);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    // Memory access: expect forwarding, then return data two cycles later.
    task automatic do_mem(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] k,
                          input string tag);
        exp_t e;
        e.data  = {a, ~a};
        e.fault = 1'b0;
        e.cause = 4'd0;
        e.tag   = tag;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_kind = k;
        #1;
        check({tag, " R2 mem_req_valid"}, {63'b0, mem_req_valid}, 64'd1);
        check({tag, " R2 mem_req_addr"}, {32'b0, mem_req_addr}, {32'b0, a});
        check({tag, " R2 mem_req_size"}, {62'b0, mem_req_size}, {62'b0, sz});
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        sb.push_back(e);
        mem_rsp_valid = 1'b1; mem_rsp_data = {a, ~a};
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare each response against the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && rsp_valid) begin
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R9 unexpected response: actual data %h expected none", rsp_data);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " data"},  rsp_data, e.data);
                    check({e.tag, " fault"}, {63'b0, rsp_fault}, {63'b0, e.fault});
                    check({e.tag, " cause"}, {60'b0, rsp_cause}, {60'b0, e.cause});
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", {63'b0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        check("R1 rsp_valid after reset", {63'b0, rsp_valid}, 64'd0);
        check("R1 mem_req_valid after reset", {63'b0, mem_req_valid}, 64'd0);

        // R3 timer reads
        do_local(TB,            2'd2, 2'd1, 1'b0, 64'd1, "R3 sip 4B");
        do_local(TB,            2'd3, 2'd1, 1'b0, 64'd1, "R3 sip 8B");
        do_local(TB + 'h4000,   2'd3, 2'd1, 1'b0, CMP_V, "R3 cmp 8B");
        do_local(TB + 'h4000,   2'd2, 2'd1, 1'b0, {32'b0, CMP_V[31:0]}, "R3 cmp lo");
        do_local(TB + 'h4004,   2'd2, 2'd0, 1'b0, {32'b0, CMP_V[63:32]}, "R3 cmp hi");
        do_local(TB + 'hBFF8,   2'd3, 2'd1, 1'b0, TIME_V, "R3 time 8B");
        do_local(TB + 'hBFF8,   2'd2, 2'd2, 1'b0, {32'b0, TIME_V[31:0]}, "R3 time lo");
        do_local(TB + 'hBFFC,   2'd2, 2'd1, 1'b0, {32'b0, TIME_V[63:32]}, "R3 time hi");
        // R4 timer rejections
        do_local(TB,            2'd1, 2'd1, 1'b1, 64'd0, "R4 sip 2B");
        do_local(TB + 'h4004,   2'd3, 2'd1, 1'b1, 64'd0, "R4 cmp hi 8B");
        do_local(TB + 'h10,     2'd2, 2'd0, 1'b1, 64'd0, "R4 off 0x10");
        // R5 / R6 mailbox
        do_local(HB,            2'd2, 2'd1, 1'b0, {32'b0, HOST_V[31:0]}, "R5 host lo");
        do_local(HB + 4,        2'd2, 2'd1, 1'b0, {32'b0, HOST_V[63:32]}, "R5 host hi");
        do_local(HB,            2'd3, 2'd1, 1'b1, 64'd0, "R6 host 8B");
        do_local(HB + 8,        2'd2, 2'd2, 1'b1, 64'd0, "R6 host +8");
        // R7 cause per kind on an unmapped address
        for (int k = 0; k < 4; k++)
            do_local(32'h1000_0000, 2'd2, 2'(k), 1'b1, 64'd0, "R7 unmapped kind");
        // R8 straddle and unmapped
        do_local(MEND - 4,      2'd3, 2'd1, 1'b1, 64'd0, "R8 mem straddle");
        do_local(HB + 'hC,      2'd3, 2'd0, 1'b1, 64'd0, "R8 host straddle");
        do_local(32'h0000_0100, 2'd0, 2'd3, 1'b1, 64'd0, "R8 low unmapped");
        // R2 memory
        do_mem(MB,              2'd3, 2'd0, "R2 mem base");
        do_mem(MB + 'h1234,     2'd1, 2'd1, "R2 mem mid");
        do_mem(MEND - 8,        2'd3, 2'd2, "R2 mem top");

        repeat (4) @(negedge clk);
        check("R9 scoreboard drained", 64'(sb.size()), 64'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule